// File: doc/BRIEF.md
# Signal Power Freeze Detector

This block sits beside a background interleave-calibration engine and judges whether the digitized input carries enough power for the gain and timing-skew estimators to learn from it. Each valid sample is first aligned so that its most significant bit lands on bit 11 of a 12-bit word, whatever the converter resolution. It is then squared and summed over a window whose length is a power of two. The mean of that window is compared against a programmable power threshold.

The comparison has hysteresis. While tracking, a mean below the threshold sends the block to Hold. While holding, the mean must reach at least the threshold plus the hysteresis before tracking resumes. Hold freezes only the gain and skew estimators; the offset estimator keeps running unless the whole block is disabled. The latest window mean is also presented on an output, so the surrounding logic can observe it.

Top module: `sig_power_freeze`

## Requirements
- R1: Sample alignment. `res_bits` gives the converter width, clamped to the range 8..12. The sample is right-justified in `smp`, and bits above the resolution are ignored. It is shifted left by (12 − resolution) before use, with bit 11 taken as the sign.
- R2: Squaring. The aligned sample is a signed two's complement value. It is squared into an unsigned 24-bit value, so the most negative code (−2048) gives 0x400000.
- R3: Window mean. `win_log2` gives the window length as a power of two, clamped to 4..10. The window is that many valid samples.
  - The reported mean is the floor of the window sum divided by the window length.
  - `mean_pwr` changes only when a window completes.
  - No overflow occurs, even at the largest window with full-scale samples.
- R4: Threshold placement. The 24-bit threshold is `thr_reg` placed at bits 19:4, with bits 23:20 and 3:0 at zero.
- R5: In Track, a completed window with mean strictly below the threshold moves the block to Hold.
- R6: In Hold, a completed window moves the block to Track only when the mean is greater than or equal to (threshold + hysteresis).
  - The hysteresis value is `hyst_reg` at bits 11:4, with all other bits at zero.
  - The sum is formed at 25 bits.
  - Otherwise the block stays in Hold.
- R7: `freeze_gs` is high exactly when the state is Hold. `freeze_off` is high only while the block is disabled, following `en` low with one cycle of delay.
- R8: Reset or `en` low produces the following.
  - Hold, with `hold` = 1.
  - All freeze flags high.
  - `mean_pwr` = 0.
  - Any partly accumulated window discarded, so the next window after enabling starts fresh.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| en | input | 1 | Block enable; low clears and holds |
| smp_vld | input | 1 | Sample strobe |
| smp | input | 12 | Right-justified signed sample |
| res_bits | input | 4 | Converter resolution, 8..12 |
| win_log2 | input | 4 | log2 of window length, 4..10 |
| thr_reg | input | 16 | Power threshold field |
| hyst_reg | input | 8 | Hysteresis field |
| hold | output | 1 | 1 = Hold, 0 = Track |
| freeze_gs | output | 1 | Freeze gain and skew estimation |
| freeze_off | output | 1 | Freeze offset estimation |
| mean_pwr | output | 24 | Latest window mean power |

## Verification
The threshold is first swept one amplitude step at a time, upward and then downward, across the power boundary. This shows whether the falling edge uses a strict "below the threshold" comparison and the rising edge an "at least threshold plus hysteresis" comparison. A second sweep with a different threshold and the largest hysteresis confirms where each field sits in the power word. Windows that mix two amplitudes, negative full-scale codes and eight-bit samples with junk in the upper bits separate correct averaging, squaring and alignment from near misses. Changing the window length, clamping its setting, and disabling the block mid-window show when the mean updates and that a partial sum is discarded.

// File: rtl/spf_pkg.sv
package spf_pkg;
   typedef enum logic {
      ST_TRACK = 1'b0,
      ST_HOLD  = 1'b1
   } spf_state_e;

   // Bit offsets of the programmable fields inside the 24-bit power word
   localparam int THR_LSB = 4;
   localparam int HYS_LSB = 4;
endpackage

// File: rtl/spf_square.sv
module spf_square #(
   parameter int SMP_W     = 12,
   parameter int MIN_RES   = 8,
   parameter int RES_SEL_W = 4
) (
   input  logic                   clk,
   input  logic                   rst_n,
   input  logic                   en,
   input  logic                   in_vld,
   input  logic [SMP_W-1:0]       in_smp,
   input  logic [RES_SEL_W-1:0]   res_bits,
   output logic                   out_vld,
   output logic [2*SMP_W-1:0]     out_sq
);
   localparam int SQ_W  = 2 * SMP_W;
   localparam int NRES  = SMP_W - MIN_RES + 1;
   localparam int IDX_W = (NRES > 1) ? $clog2(NRES) : 1;

   logic [SMP_W-1:0] cand [NRES];
   logic [IDX_W-1:0] idx;
   logic [SMP_W-1:0] aligned;
   logic [SMP_W-1:0] mag;
   logic [SQ_W-1:0]  sq_c;

   // One left-aligned candidate per supported resolution
   for (genvar gi = 0; gi < NRES; gi++) begin : g_align
      assign cand[gi] = in_smp << (SMP_W - MIN_RES - gi);
   end

   always_comb begin
      if (res_bits < RES_SEL_W'(MIN_RES))
         idx = '0;
      else if (res_bits > RES_SEL_W'(SMP_W))
         idx = IDX_W'(NRES - 1);
      else
         idx = IDX_W'(res_bits - RES_SEL_W'(MIN_RES));
   end

   assign aligned = cand[idx];
   assign mag     = aligned[SMP_W-1] ? (~aligned + 1'b1) : aligned;
   assign sq_c    = SQ_W'(mag) * SQ_W'(mag);

   always_ff @(posedge clk) begin
      if (!rst_n || !en) begin
         out_vld <= 1'b0;
         out_sq  <= '0;
      end else begin
         out_vld <= in_vld;
         if (in_vld) out_sq <= sq_c;
      end
   end

   // R2: the square never exceeds (2^(SMP_W-1))^2
   a_r2_sq_bound: assert property (@(posedge clk) disable iff (!rst_n)
      out_vld |-> (out_sq <= (SQ_W'(1) << (2*SMP_W-2))));
endmodule

// File: rtl/spf_window_acc.sv
module spf_window_acc #(
   parameter int SQ_W         = 24,
   parameter int WIN_MIN_LOG2 = 4,
   parameter int WIN_MAX_LOG2 = 10,
   parameter int WSEL_W       = 4
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              en,
   input  logic              in_vld,
   input  logic [SQ_W-1:0]   in_sq,
   input  logic [WSEL_W-1:0] win_log2,
   output logic              mean_vld,
   output logic [SQ_W-1:0]   mean
);
   localparam int ACC_W = SQ_W + WIN_MAX_LOG2;
   localparam int CNT_W = WIN_MAX_LOG2;

   logic [WSEL_W-1:0] eff;
   logic [CNT_W:0]    win_len;
   logic [CNT_W-1:0]  cnt;
   logic [ACC_W-1:0]  acc;
   logic [ACC_W-1:0]  sum_nxt;
   logic              last;

   if (WIN_MIN_LOG2 == WIN_MAX_LOG2) begin : g_fixed_win
      assign eff = WSEL_W'(WIN_MIN_LOG2);
   end else begin : g_prog_win
      always_comb begin
         if (win_log2 < WSEL_W'(WIN_MIN_LOG2))
            eff = WSEL_W'(WIN_MIN_LOG2);
         else if (win_log2 > WSEL_W'(WIN_MAX_LOG2))
            eff = WSEL_W'(WIN_MAX_LOG2);
         else
            eff = win_log2;
      end
   end

   assign win_len = (CNT_W+1)'(1) << eff;
   assign last    = ({1'b0, cnt} == (win_len - 1'b1));
   assign sum_nxt = acc + ACC_W'(in_sq);

   always_ff @(posedge clk) begin
      if (!rst_n || !en) begin
         acc      <= '0;
         cnt      <= '0;
         mean     <= '0;
         mean_vld <= 1'b0;
      end else begin
         mean_vld <= 1'b0;
         if (in_vld) begin
            if (last) begin
               acc      <= '0;
               cnt      <= '0;
               mean     <= SQ_W'(sum_nxt >> eff);
               mean_vld <= 1'b1;
            end else begin
               acc <= sum_nxt;
               cnt <= cnt + 1'b1;
            end
         end
      end
   end

   // R3: the sample counter stays inside the selected window
   a_r3_cnt_in_window: assert property (@(posedge clk) disable iff (!rst_n)
      ({1'b0, cnt} < win_len));
   // R3: the accumulated sum never reaches the top bit (no overflow)
   a_r3_no_overflow: assert property (@(posedge clk) disable iff (!rst_n)
      !acc[ACC_W-1]);
   // R3: the mean only changes with a completed window or a clear
   a_r3_mean_steady: assert property (@(posedge clk) disable iff (!rst_n)
      (en && !(in_vld && last)) |=> $stable(mean));
endmodule

// File: rtl/spf_hyst_fsm.sv
module spf_hyst_fsm
   import spf_pkg::*;
#(
   parameter int SQ_W  = 24,
   parameter int THR_W = 16,
   parameter int HYS_W = 8
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             en,
   input  logic             mean_vld,
   input  logic [SQ_W-1:0]  mean,
   input  logic [THR_W-1:0] thr_reg,
   input  logic [HYS_W-1:0] hyst_reg,
   output logic             hold,
   output logic             freeze_gs,
   output logic             freeze_off
);
   spf_state_e      state;
   logic [SQ_W-1:0] thr_w;
   logic [SQ_W-1:0] hys_w;
   logic [SQ_W:0]   rise_w;
   logic            below;
   logic            above;

   assign thr_w  = SQ_W'(thr_reg)  << THR_LSB;
   assign hys_w  = SQ_W'(hyst_reg) << HYS_LSB;
   assign rise_w = {1'b0, thr_w} + {1'b0, hys_w};
   assign below  = (mean < thr_w);
   assign above  = ({1'b0, mean} >= rise_w);

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         state      <= ST_HOLD;
         freeze_off <= 1'b1;
      end else begin
         freeze_off <= !en;
         if (!en) begin
            state <= ST_HOLD;
         end else if (mean_vld) begin
            case (state)
               ST_TRACK: if (below) state <= ST_HOLD;
               ST_HOLD:  if (above) state <= ST_TRACK;
               default:  state <= ST_HOLD;
            endcase
         end
      end
   end

   assign hold      = (state == ST_HOLD);
   assign freeze_gs = hold;

   // R5: a weak window while tracking leads to Hold
   a_r5_track_to_hold: assert property (@(posedge clk) disable iff (!rst_n)
      (en && mean_vld && !hold && below) |=> hold);
   // R6: a strong enough window while holding leads to Track
   a_r6_hold_to_track: assert property (@(posedge clk) disable iff (!rst_n)
      (en && mean_vld && hold && above) |=> !hold);
   // R6: below threshold+hysteresis the block stays in Hold
   a_r6_hold_stays: assert property (@(posedge clk) disable iff (!rst_n)
      (hold && !(en && mean_vld && above)) |=> hold);
   // R7: without a completed window the state does not move
   a_r7_state_quiet: assert property (@(posedge clk) disable iff (!rst_n)
      (en && !mean_vld) |=> $stable(state));
   // R8: disabling forces Hold and freezes offset estimation
   a_r8_disable_hold: assert property (@(posedge clk) disable iff (!rst_n)
      !en |=> (hold && freeze_off));
endmodule

// File: rtl/sig_power_freeze.sv
module sig_power_freeze #(
   parameter int SMP_W        = 12,
   parameter int MIN_RES      = 8,
   parameter int RES_SEL_W    = 4,
   parameter int WIN_MIN_LOG2 = 4,
   parameter int WIN_MAX_LOG2 = 10,
   parameter int WSEL_W       = 4,
   parameter int THR_W        = 16,
   parameter int HYS_W        = 8
) (
   input  logic                   clk,
   input  logic                   rst_n,
   input  logic                   en,
   input  logic                   smp_vld,
   input  logic [SMP_W-1:0]       smp,
   input  logic [RES_SEL_W-1:0]   res_bits,
   input  logic [WSEL_W-1:0]      win_log2,
   input  logic [THR_W-1:0]       thr_reg,
   input  logic [HYS_W-1:0]       hyst_reg,
   output logic                   hold,
   output logic                   freeze_gs,
   output logic                   freeze_off,
   output logic [2*SMP_W-1:0]     mean_pwr
);
   localparam int SQ_W = 2 * SMP_W;

   if (SMP_W != 12) begin : g_bad_smp_w
      $error("sig_power_freeze: power word layout assumes 12-bit samples");
   end
   if (MIN_RES < 1 || MIN_RES > SMP_W) begin : g_bad_min_res
      $error("sig_power_freeze: MIN_RES out of range");
   end
   if (WIN_MIN_LOG2 > WIN_MAX_LOG2) begin : g_bad_win
      $error("sig_power_freeze: window bounds reversed");
   end
   if ((1 << WSEL_W) <= WIN_MAX_LOG2) begin : g_bad_wsel
      $error("sig_power_freeze: win_log2 too narrow");
   end
   if (spf_pkg::THR_LSB + THR_W > SQ_W || spf_pkg::HYS_LSB + HYS_W > SQ_W) begin : g_bad_fields
      $error("sig_power_freeze: field does not fit power word");
   end

   logic            sq_vld;
   logic [SQ_W-1:0] sq;
   logic            mean_vld;

   spf_square #(
      .SMP_W     (SMP_W),
      .MIN_RES   (MIN_RES),
      .RES_SEL_W (RES_SEL_W)
   ) u_square (
      .clk      (clk),
      .rst_n    (rst_n),
      .en       (en),
      .in_vld   (smp_vld),
      .in_smp   (smp),
      .res_bits (res_bits),
      .out_vld  (sq_vld),
      .out_sq   (sq)
   );

   spf_window_acc #(
      .SQ_W         (SQ_W),
      .WIN_MIN_LOG2 (WIN_MIN_LOG2),
      .WIN_MAX_LOG2 (WIN_MAX_LOG2),
      .WSEL_W       (WSEL_W)
   ) u_acc (
      .clk      (clk),
      .rst_n    (rst_n),
      .en       (en),
      .in_vld   (sq_vld),
      .in_sq    (sq),
      .win_log2 (win_log2),
      .mean_vld (mean_vld),
      .mean     (mean_pwr)
   );

   spf_hyst_fsm #(
      .SQ_W  (SQ_W),
      .THR_W (THR_W),
      .HYS_W (HYS_W)
   ) u_fsm (
      .clk        (clk),
      .rst_n      (rst_n),
      .en         (en),
      .mean_vld   (mean_vld),
      .mean       (mean_pwr),
      .thr_reg    (thr_reg),
      .hyst_reg   (hyst_reg),
      .hold       (hold),
      .freeze_gs  (freeze_gs),
      .freeze_off (freeze_off)
   );

   // R7: gain/skew freeze always mirrors the Hold state
   a_r7_gs_follows_hold: assert property (@(posedge clk) disable iff (!rst_n)
      freeze_gs == hold);
   // R8: while disabled the reported mean is cleared
   a_r8_mean_cleared: assert property (@(posedge clk) disable iff (!rst_n)
      !en |=> (mean_pwr == '0));
endmodule

// File: tb/sig_power_freeze_tb.sv
module sig_power_freeze_tb_top;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        en = 1'b0;
   logic        smp_vld = 1'b0;
   logic [11:0] smp = '0;
   logic [3:0]  res_bits = 4'd12;
   logic [3:0]  win_log2 = 4'd4;
   logic [15:0] thr_reg = 16'h1000;
   logic [7:0]  hyst_reg = 8'h10;
   logic        hold, freeze_gs, freeze_off;
   logic [23:0] mean_pwr;

   int  n_chk = 0;
   int  n_fail = 0;
   bit  done = 1'b0;
   bit  exp_hold = 1'b1;

   always #4 clk = ~clk;

   sig_power_freeze dut_i (
      .clk(clk), .rst_n(rst_n), .en(en), .smp_vld(smp_vld), .smp(smp),
      .res_bits(res_bits), .win_log2(win_log2), .thr_reg(thr_reg),
      .hyst_reg(hyst_reg), .hold(hold), .freeze_gs(freeze_gs),
      .freeze_off(freeze_off), .mean_pwr(mean_pwr)
   );

   task automatic chk(input string req, input string what,
                      input longint act, input longint exp);
      n_chk++;
      if (act != exp) begin
         n_fail++;
         $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
      end
   endtask

   // Alternate two raw codes for n samples, then let the pipeline settle
   task automatic feed(input logic [11:0] ev, input logic [11:0] od, input int n);
      for (int k = 0; k < n; k++) begin
         @(negedge clk);
         smp_vld = 1'b1;
         smp = (k % 2 == 0) ? ev : od;
      end
      @(negedge clk);
      smp_vld = 1'b0;
      repeat (3) @(negedge clk);
   endtask

   // Model of the hysteresis rule (R5, R6)
   task automatic model_step(input longint m);
      longint thr24 = longint'(thr_reg) << 4;
      longint rise  = thr24 + (longint'(hyst_reg) << 4);
      if (!exp_hold && m < thr24) exp_hold = 1'b1;
      else if (exp_hold && m >= rise) exp_hold = 1'b0;
   endtask

   task automatic set_enable(input bit v);
      @(negedge clk);
      en = v;
      repeat (2) @(negedge clk);
      if (!v) exp_hold = 1'b1;
   endtask

   task automatic amp_window(input int amp, input string req);
      longint m = longint'(amp) * amp;
      feed(12'(amp), 12'(-amp), 16);
      model_step(m);
      chk("R3", "window mean", mean_pwr, m);
      chk(req, $sformatf("hold at amp %0d", amp), hold, exp_hold);
      chk("R7", "freeze_gs tracks hold", freeze_gs, exp_hold);
      chk("R7", "offset free while enabled", freeze_off, 0);
   endtask

   initial begin
      repeat (5) @(negedge clk);
      chk("R8", "reset hold", hold, 1);
      chk("R8", "reset freeze_gs", freeze_gs, 1);
      chk("R8", "reset freeze_off", freeze_off, 1);
      chk("R8", "reset mean", mean_pwr, 0);
      rst_n = 1'b1;
      set_enable(1'b1);
      chk("R7", "freeze_off drops after enable", freeze_off, 0);
      chk("R8", "still Hold before any window", hold, 1);

      // Sweep across threshold 0x10000 with rise 0x10100 (R4, R5, R6)
      for (int a = 240; a <= 272; a++) amp_window(a, (a < 257) ? "R6" : "R4");
      for (int a = 272; a >= 240; a--) amp_window(a, "R5");

      // Averaging of two different powers, negative odd samples (R2, R3)
      feed(12'd300, 12'(-200), 16);
      chk("R3", "mixed mean", mean_pwr, (90000 + 40000) / 2);
      feed(12'h800, 12'h800, 16);
      chk("R2", "most negative code squared", mean_pwr, 64'h400000);
      model_step(64'h400000);
      chk("R6", "full scale enters Track", hold, exp_hold);

      // Eight-bit samples with junk in the upper nibble (R1)
      set_enable(1'b0);
      res_bits = 4'd8;
      set_enable(1'b1);
      feed(12'hA80, 12'h57F, 16);
      chk("R1", "8-bit alignment", mean_pwr, (4194304 + 2032 * 2032) / 2);
      feed(12'hF10, 12'hF10, 16);
      chk("R1", "8-bit small code", mean_pwr, 256 * 256);
      set_enable(1'b0);
      res_bits = 4'd15;
      set_enable(1'b1);
      feed(12'h801, 12'h801, 16);
      chk("R1", "resolution above 12 clamps to 12", mean_pwr, 2047 * 2047);
      set_enable(1'b0);
      res_bits = 4'd3;
      set_enable(1'b1);
      feed(12'h0FF, 12'h0FF, 16);
      chk("R1", "resolution below 8 clamps to 8", mean_pwr, 16 * 16);

      // Window length (R3)
      set_enable(1'b0);
      res_bits = 4'd12;
      win_log2 = 4'd5;
      set_enable(1'b1);
      feed(12'd500, 12'd500, 16);
      chk("R3", "no update after half of 32", mean_pwr, 0);
      feed(12'd100, 12'd100, 16);
      chk("R3", "32-sample mean", mean_pwr, (16 * 250000 + 16 * 10000) / 32);
      set_enable(1'b0);
      win_log2 = 4'd0;
      set_enable(1'b1);
      feed(12'd400, 12'd400, 8);
      chk("R3", "clamped window not done at 8", mean_pwr, 0);
      feed(12'd400, 12'd400, 8);
      chk("R3", "clamped window done at 16", mean_pwr, 160000);
      set_enable(1'b0);
      win_log2 = 4'd10;
      set_enable(1'b1);
      feed(12'h800, 12'h800, 1024);
      chk("R3", "largest window no overflow", mean_pwr, 64'h400000);
      exp_hold = 1'b1;
      model_step(64'h400000);
      chk("R6", "large window to Track", hold, exp_hold);

      // Disable mid-window discards partial sum (R8)
      set_enable(1'b0);
      win_log2 = 4'd4;
      chk("R8", "disabled hold", hold, 1);
      chk("R8", "disabled freeze_gs", freeze_gs, 1);
      chk("R8", "disabled freeze_off", freeze_off, 1);
      chk("R8", "disabled mean", mean_pwr, 0);
      set_enable(1'b1);
      feed(12'd2000, 12'd2000, 8);
      set_enable(1'b0);
      set_enable(1'b1);
      feed(12'd100, 12'd100, 16);
      chk("R8", "partial window discarded", mean_pwr, 10000);

      // Second sweep: thr 0x8000, hysteresis 0xFF0 (R4, R6)
      set_enable(1'b0);
      thr_reg = 16'h0800;
      hyst_reg = 8'hFF;
      set_enable(1'b1);
      for (int a = 175; a <= 200; a++) amp_window(a, "R6");
      for (int a = 200; a >= 175; a--) amp_window(a, "R4");

      if (!done) begin
         done = 1'b1;
         $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
         $finish;
      end
   end

   initial begin
      repeat (200000) @(posedge clk);
      if (!done) begin
         done = 1'b1;
         n_chk++;
         n_fail++;
         $display("FAIL watchdog: actual timeout expected completion");
         $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
         $finish;
      end
   end
endmodule